// File: doc/BRIEF.md
# Pixel Address Window Write Engine

This block sits behind the byte receiver of a display controller. Each byte arrives with a strobe and a flag that marks it as a command or as data. The block tracks which command is open and collects the arguments of the column-range and row-range commands. While a memory-write command is open, it packs pairs of data bytes into 16-bit RGB565 pixels and sends each pixel to a framebuffer write port as an (x, y, color) write.

Pixel positions do not run through a flat address space. They step through a programmable rectangle. The column advances first. At the right edge of the rectangle the column returns to its start and the row steps down. At the bottom edge the row returns to its start, so a long stream keeps refilling the same rectangle. Raising the active-low select line cancels the byte sequence in progress.

Top module: `pixwin_top`

## Requirements
- R1: After reset the rectangle covers the whole frame (columns 0 to H_PIX-1, rows 0 to V_PIX-1), the cursor is at (0,0), no command is open and px_we is low.
- R2: Command byte 0x2A opens a column-range command. Its next four data bytes are start high, start low, end high and end low. The new column bounds take effect when the fourth byte is accepted. Any further data bytes for that command are ignored.
- R3: Command byte 0x2B opens a row-range command, with the same four-byte argument order and the same commit rule as R2.
- R4: A bound value above the last column (H_PIX-1) or the last row (V_PIX-1) is saturated to that last column or row.
- R5: Command byte 0x2C moves the cursor to (column start, row start). Each following pair of data bytes forms one pixel, with the first byte as color bits 15:8 and the second as bits 7:0. px_we is high for exactly one cycle, in the cycle after the second byte is accepted, carrying the pixel's x, y and color.
- R6: After each pixel the column increments. When the written column equals or exceeds the column end, or is the last frame column, the next column is the column start and the row advances as in R7.
- R7: When the row wraps by R6 and the current row equals or exceeds the row end, or is the last frame row, the next row is the row start. Otherwise the row increments.
- R8: While cs_n is high, bytes are ignored, any half-received pixel is dropped and the open command is closed. Data bytes after reselection produce no writes until a new command byte arrives.
- R9: Any command byte other than 0x2A, 0x2B or 0x2C closes the open command, and its data bytes are ignored. A command byte never causes a pixel write.
- R10: Inputs are accepted only in cycles where byte_valid is high. In other cycles the state does not change and px_we stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high cancels the current sequence |
| is_data | input | 1 | 1 = data byte, 0 = command byte |
| byte_valid | input | 1 | Byte strobe, one byte per high cycle |
| byte_data | input | 8 | Received byte |
| px_we | output | 1 | Pixel write strobe, one cycle per pixel |
| px_x | output | XW (9) | Pixel column |
| px_y | output | YW (8) | Pixel row |
| px_color | output | 16 | RGB565 pixel value |

## Verification
The bench builds the block with its default 320x240 frame. This puts both saturation edges, column 319 and row 239, within reach of the directed cases. Random windows are a few pixels wide and tall, sometimes with an end bound below the start bound, so column wraps, row wraps and full-rectangle wraps occur many times per memory write. Random deselects and unknown command codes are mixed into the stream, so that a dropped half pixel or a stray write shows up at once on the write port.

// File: rtl/pixwin_pkg.sv
package pixwin_pkg;

    localparam logic [7:0] OP_COLSET = 8'h2A;
    localparam logic [7:0] OP_ROWSET = 8'h2B;
    localparam logic [7:0] OP_MEMWR  = 8'h2C;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_COL  = 2'd1,
        CMD_ROW  = 2'd2,
        CMD_MEMW = 2'd3
    } cmd_e;

    typedef struct packed {
        cmd_e        cmd;
        logic [2:0]  idx;
        logic [23:0] shadow;
        logic [7:0]  hi;
        logic        half;
    } prs_t;

endpackage

// File: rtl/pixwin_parser.sv
module pixwin_parser
    import pixwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        is_data,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    output logic        bnd_load,
    output logic        bnd_row,
    output logic [15:0] bnd_start,
    output logic [15:0] bnd_end,
    output logic        memw_go,
    output logic        pix_go,
    output logic [15:0] pix_color
);

    prs_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        bnd_load  = 1'b0;
        bnd_row   = (st_q.cmd == CMD_ROW);
        bnd_start = st_q.shadow[23:8];
        bnd_end   = {st_q.shadow[7:0], byte_data};
        memw_go   = 1'b0;
        pix_go    = 1'b0;
        pix_color = {st_q.hi, byte_data};

        if (cs_n) begin
            st_d.cmd  = CMD_NONE;
            st_d.idx  = '0;
            st_d.half = 1'b0;
        end else if (byte_valid) begin
            if (!is_data) begin
                st_d.idx  = '0;
                st_d.half = 1'b0;
                case (byte_data)
                    OP_COLSET: st_d.cmd = CMD_COL;
                    OP_ROWSET: st_d.cmd = CMD_ROW;
                    OP_MEMWR: begin
                        st_d.cmd = CMD_MEMW;
                        memw_go  = 1'b1;
                    end
                    default:   st_d.cmd = CMD_NONE;
                endcase
            end else begin
                case (st_q.cmd)
                    CMD_COL, CMD_ROW: begin
                        case (st_q.idx)
                            3'd0: st_d.shadow[23:16] = byte_data;
                            3'd1: st_d.shadow[15:8]  = byte_data;
                            3'd2: st_d.shadow[7:0]   = byte_data;
                            3'd3: bnd_load           = 1'b1;
                            default: ;
                        endcase
                        if (st_q.idx < 3'd4) begin
                            st_d.idx = st_q.idx + 3'd1;
                        end
                    end
                    CMD_MEMW: begin
                        if (!st_q.half) begin
                            st_d.hi   = byte_data;
                            st_d.half = 1'b1;
                        end else begin
                            pix_go    = 1'b1;
                            st_d.half = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cmd: CMD_NONE, idx: '0, shadow: '0, hi: '0, half: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pixwin_bounds.sv
module pixwin_bounds #(
    parameter int H_PIX = 320,
    parameter int V_PIX = 240,
    localparam int XW = $clog2(H_PIX),
    localparam int YW = $clog2(V_PIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bnd_load,
    input  logic          bnd_row,
    input  logic [15:0]   bnd_start,
    input  logic [15:0]   bnd_end,
    output logic [XW-1:0] col_lo,
    output logic [XW-1:0] col_hi,
    output logic [YW-1:0] row_lo,
    output logic [YW-1:0] row_hi
);

    localparam logic [15:0] XMAX = 16'(H_PIX - 1);
    localparam logic [15:0] YMAX = 16'(V_PIX - 1);

    typedef struct packed {
        logic [XW-1:0] xs;
        logic [XW-1:0] xe;
        logic [YW-1:0] ys;
        logic [YW-1:0] ye;
    } win_t;

    win_t w_d, w_q;

    function automatic logic [XW-1:0] sat_x(input logic [15:0] v);
        logic [15:0] c;
        c = (v > XMAX) ? XMAX : v;
        return c[XW-1:0];
    endfunction

    function automatic logic [YW-1:0] sat_y(input logic [15:0] v);
        logic [15:0] c;
        c = (v > YMAX) ? YMAX : v;
        return c[YW-1:0];
    endfunction

    always_comb begin
        w_d = w_q;
        if (bnd_load) begin
            if (bnd_row) begin
                w_d.ys = sat_y(bnd_start);
                w_d.ye = sat_y(bnd_end);
            end else begin
                w_d.xs = sat_x(bnd_start);
                w_d.xe = sat_x(bnd_end);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{xs: '0, xe: XMAX[XW-1:0], ys: '0, ye: YMAX[YW-1:0]};
        end else begin
            w_q <= w_d;
        end
    end

    assign col_lo = w_q.xs;
    assign col_hi = w_q.xe;
    assign row_lo = w_q.ys;
    assign row_hi = w_q.ye;

endmodule

// File: rtl/pixwin_cursor.sv
module pixwin_cursor #(
    parameter int H_PIX = 320,
    parameter int V_PIX = 240,
    localparam int XW = $clog2(H_PIX),
    localparam int YW = $clog2(V_PIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          memw_go,
    input  logic          pix_go,
    input  logic [15:0]   pix_color,
    input  logic [XW-1:0] col_lo,
    input  logic [XW-1:0] col_hi,
    input  logic [YW-1:0] row_lo,
    input  logic [YW-1:0] row_hi,
    output logic          px_we,
    output logic [XW-1:0] px_x,
    output logic [YW-1:0] px_y,
    output logic [15:0]   px_color
);

    localparam logic [XW-1:0] XLAST = XW'(H_PIX - 1);
    localparam logic [YW-1:0] YLAST = YW'(V_PIX - 1);

    typedef struct packed {
        logic [XW-1:0] x;
        logic [YW-1:0] y;
        logic          we;
        logic [XW-1:0] ox;
        logic [YW-1:0] oy;
        logic [15:0]   oc;
    } cur_t;

    cur_t c_d, c_q;
    logic col_wrap, row_wrap;

    always_comb begin
        c_d      = c_q;
        c_d.we   = 1'b0;
        col_wrap = (c_q.x >= col_hi) || (c_q.x == XLAST);
        row_wrap = (c_q.y >= row_hi) || (c_q.y == YLAST);

        if (memw_go) begin
            c_d.x = col_lo;
            c_d.y = row_lo;
        end else if (pix_go) begin
            c_d.we = 1'b1;
            c_d.ox = c_q.x;
            c_d.oy = c_q.y;
            c_d.oc = pix_color;
            if (col_wrap) begin
                c_d.x = col_lo;
                c_d.y = row_wrap ? row_lo : c_q.y + YW'(1);
            end else begin
                c_d.x = c_q.x + XW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign px_we    = c_q.we;
    assign px_x     = c_q.ox;
    assign px_y     = c_q.oy;
    assign px_color = c_q.oc;

endmodule

// File: rtl/pixwin_top.sv
module pixwin_top #(
    parameter int H_PIX = 320,
    parameter int V_PIX = 240,
    localparam int XW = $clog2(H_PIX),
    localparam int YW = $clog2(V_PIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          is_data,
    input  logic          byte_valid,
    input  logic [7:0]    byte_data,
    output logic          px_we,
    output logic [XW-1:0] px_x,
    output logic [YW-1:0] px_y,
    output logic [15:0]   px_color
);

    logic          bnd_load, bnd_row, memw_go, pix_go;
    logic [15:0]   bnd_start, bnd_end, pix_color;
    logic [XW-1:0] col_lo, col_hi;
    logic [YW-1:0] row_lo, row_hi;

    pixwin_parser u_parser (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .is_data    (is_data),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .bnd_load   (bnd_load),
        .bnd_row    (bnd_row),
        .bnd_start  (bnd_start),
        .bnd_end    (bnd_end),
        .memw_go    (memw_go),
        .pix_go     (pix_go),
        .pix_color  (pix_color)
    );

    pixwin_bounds #(.H_PIX(H_PIX), .V_PIX(V_PIX)) u_bounds (
        .clk       (clk),
        .rst_n     (rst_n),
        .bnd_load  (bnd_load),
        .bnd_row   (bnd_row),
        .bnd_start (bnd_start),
        .bnd_end   (bnd_end),
        .col_lo    (col_lo),
        .col_hi    (col_hi),
        .row_lo    (row_lo),
        .row_hi    (row_hi)
    );

    pixwin_cursor #(.H_PIX(H_PIX), .V_PIX(V_PIX)) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .memw_go   (memw_go),
        .pix_go    (pix_go),
        .pix_color (pix_color),
        .col_lo    (col_lo),
        .col_hi    (col_hi),
        .row_lo    (row_lo),
        .row_hi    (row_hi),
        .px_we     (px_we),
        .px_x      (px_x),
        .px_y      (px_y),
        .px_color  (px_color)
    );

endmodule

// File: rtl/pixwin_chk.sv
module pixwin_chk #(
    parameter int H_PIX = 320,
    parameter int V_PIX = 240,
    localparam int XW = $clog2(H_PIX),
    localparam int YW = $clog2(V_PIX)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          is_data,
    input logic          byte_valid,
    input logic          px_we,
    input logic [XW-1:0] px_x,
    input logic [YW-1:0] px_y
);

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        px_we |=> !px_we);                                              // R5
    AST_X_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        px_we |-> (int'(px_x) < H_PIX));                                // R4
    AST_Y_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        px_we |-> (int'(px_y) < V_PIX));                                // R4
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !px_we);                                               // R8
    AST_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !is_data) |=> !px_we);                           // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> !px_we);                                        // R10

endmodule

bind pixwin_top pixwin_chk #(.H_PIX(H_PIX), .V_PIX(V_PIX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .is_data    (is_data),
    .byte_valid (byte_valid),
    .px_we      (px_we),
    .px_x       (px_x),
    .px_y       (px_y)
);

// File: tb/test_pixwin_top.sv
module test_pixwin_top;

    localparam int H = 320;
    localparam int V = 240;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       is_data = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       px_we;
    logic [8:0] px_x;
    logic [7:0] px_y;
    logic [15:0] px_color;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pixwin_top i_pixwin_top (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .is_data(is_data),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .px_we(px_we), .px_x(px_x), .px_y(px_y), .px_color(px_color)
    );

    // reference state derived from the requirements
    int m_xs, m_xe, m_ys, m_ye, m_x, m_y, m_idx, m_cmd, m_half;
    int m_sh [3];
    int m_hi;
    int e_we, e_x, e_y, e_c;

    function automatic int sat(input int v, input int lim);
        return (v > lim - 1) ? lim - 1 : v;
    endfunction

    task automatic model_reset();
        m_xs = 0; m_xe = H - 1; m_ys = 0; m_ye = V - 1;
        m_x = 0; m_y = 0; m_idx = 0; m_cmd = 0; m_half = 0; m_hi = 0;
    endtask

    // cmd: 0 none, 1 col, 2 row, 3 memory write
    task automatic model_step(input bit cs, input bit dc, input bit v, input int b);
        e_we = 0;
        if (cs) begin
            m_cmd = 0; m_idx = 0; m_half = 0;
        end else if (v) begin
            if (!dc) begin
                m_idx = 0; m_half = 0;
                if (b == 'h2A) m_cmd = 1;
                else if (b == 'h2B) m_cmd = 2;
                else if (b == 'h2C) begin m_cmd = 3; m_x = m_xs; m_y = m_ys; end
                else m_cmd = 0;
            end else if (m_cmd == 1 || m_cmd == 2) begin
                if (m_idx < 3) m_sh[m_idx] = b;
                else if (m_idx == 3) begin
                    if (m_cmd == 1) begin
                        m_xs = sat(m_sh[0] * 256 + m_sh[1], H);
                        m_xe = sat(m_sh[2] * 256 + b, H);
                    end else begin
                        m_ys = sat(m_sh[0] * 256 + m_sh[1], V);
                        m_ye = sat(m_sh[2] * 256 + b, V);
                    end
                end
                if (m_idx < 4) m_idx++;
            end else if (m_cmd == 3) begin
                if (!m_half) begin
                    m_hi = b; m_half = 1;
                end else begin
                    m_half = 0;
                    e_we = 1; e_x = m_x; e_y = m_y; e_c = m_hi * 256 + b;
                    if (m_x >= m_xe || m_x == H - 1) begin
                        m_x = m_xs;
                        if (m_y >= m_ye || m_y == V - 1) m_y = m_ys;
                        else m_y++;
                    end else m_x++;
                end
            end
        end
    endtask

    task automatic put(input bit cs, input bit dc, input bit v, input int b, input string tag);
        @(negedge clk);
        cs_n = cs; is_data = dc; byte_valid = v; byte_data = b[7:0];
        model_step(cs, dc, v, b);
        @(negedge clk);
        byte_valid = 1'b0;
        checks++;
        if (px_we !== e_we[0]) begin
            bad++;
            $display("FAIL %s: px_we=%0b expected %0b", tag, px_we, e_we[0]);
        end else if (e_we != 0 &&
                     (int'(px_x) != e_x || int'(px_y) != e_y || int'(px_color) != e_c)) begin
            bad++;
            $display("FAIL %s: pixel (%0d,%0d,%h) expected (%0d,%0d,%h)",
                     tag, px_x, px_y, px_color, e_x, e_y, e_c[15:0]);
        end
    endtask

    task automatic cmd(input int c, input string tag);
        put(1'b0, 1'b0, 1'b1, c, tag);
    endtask

    task automatic dat(input int d, input string tag);
        put(1'b0, 1'b1, 1'b1, d, tag);
    endtask

    task automatic set_range(input int op, input int s, input int e, input string tag);
        cmd(op, tag);
        dat(s / 256, tag); dat(s % 256, tag);
        dat(e / 256, tag); dat(e % 256, tag);
    endtask

    task automatic pixels(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            int c;
            c = int'($urandom_range(0, 65535));
            dat(c / 256, tag);
            dat(c % 256, tag);
        end
    endtask

    initial begin
        void'($urandom(32'd1337));
        model_reset();
        repeat (3) @(negedge clk);
        checks++;
        if (px_we !== 1'b0) begin
            bad++;
            $display("FAIL R1: px_we=%0b in reset expected 0", px_we);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (px_we !== 1'b0) begin
            bad++;
            $display("FAIL R1: px_we=%0b after reset expected 0", px_we);
        end

        // R1: full-frame default, start at origin
        cmd('h2C, "R1");
        pixels(3, "R1");

        // R2 R3 R6 R7: 3x2 window with wraps
        set_range('h2A, 2, 4, "R2");
        set_range('h2B, 5, 6, "R3");
        cmd('h2C, "R5");
        pixels(7, "R6");
        pixels(5, "R7");

        // R2: a fifth argument byte is ignored
        set_range('h2A, 10, 12, "R2");
        dat(0, "R2");
        cmd('h2C, "R2");
        pixels(4, "R2");

        // R4: saturation at the frame edges
        set_range('h2A, 318, 'hFFFF, "R4");
        set_range('h2B, 'h00EF, 'h0100, "R4");
        cmd('h2C, "R4");
        pixels(3, "R4");
        set_range('h2B, 'h0300, 'h0400, "R4");
        cmd('h2C, "R4");
        pixels(2, "R4");

        // R8: deselect drops half pixel and closes command
        set_range('h2B, 0, 3, "R8");
        cmd('h2C, "R8");
        dat('hAB, "R8");
        put(1'b1, 1'b1, 1'b1, 'hCD, "R8");
        dat('h12, "R8");
        dat('h34, "R8");
        cmd('h2C, "R8");
        pixels(2, "R8");

        // R9: unknown command, its data is ignored
        cmd('h00, "R9");
        dat('h55, "R9");
        dat('h66, "R9");
        cmd('h2C, "R9");
        dat('h77, "R9");
        cmd('h99, "R9");
        dat('h88, "R9");

        // R10: bytes without strobe are ignored mid-pixel
        cmd('h2C, "R10");
        dat('h0F, "R10");
        put(1'b0, 1'b1, 1'b0, 'hEE, "R10");
        put(1'b0, 1'b0, 1'b0, 'h2A, "R10");
        dat('hF0, "R10");

        // constrained random mix
        for (int it = 0; it < 250; it++) begin
            int act;
            act = int'($urandom_range(0, 9));
            if (act <= 1) begin
                int s;
                s = int'($urandom_range(0, H + 4));
                set_range('h2A, s, ($urandom_range(0, 7) == 0) ? s - 2 : s + int'($urandom_range(0, 5)), "R2");
            end else if (act <= 3) begin
                int s;
                s = int'($urandom_range(0, V + 4));
                set_range('h2B, s, ($urandom_range(0, 7) == 0) ? 'hFFFF : s + int'($urandom_range(0, 4)), "R3");
            end else if (act <= 6) begin
                cmd('h2C, "R5");
                pixels(int'($urandom_range(1, 30)), "R6");
                if ($urandom_range(0, 3) == 0) dat('h5A, "R8");
            end else if (act == 7) begin
                put(1'b1, 1'b1, 1'b1, int'($urandom_range(0, 255)), "R8");
                dat(int'($urandom_range(0, 255)), "R8");
            end else if (act == 8) begin
                cmd(int'($urandom_range(0, 'h29)), "R9");
                dat(int'($urandom_range(0, 255)), "R9");
            end else begin
                put(1'b0, 1'b1, 1'b0, int'($urandom_range(0, 255)), "R10");
            end
        end

        done = 1;
    end

    initial begin
        fork
            wait (done == 1);
            begin
                repeat (150000) @(posedge clk);
                bad++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule